// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block sits between the alarm comparators of a real-time clock core and the single interrupt pin of the device. Each comparator gives a one-cycle match strobe. The block records every match in a status flag for that alarm. When that alarm's interrupt enable is set, it also drives the active-low pin low for a fixed pulse of about 20 ms, counted in the 32.768 kHz clock that runs the block.

A mode input chooses between two behaviours. In single-event mode, an alarm whose flag is still set cannot start another pulse. In recurring mode, every match starts a pulse, so a match that repeats each second, minute, hour, date or weekday gives a periodic interrupt. Software reads the flags as one status byte through a byte-serial read port: one strobe for each falling bit clock. The eighth falling bit clock of that read clears the flags. A two-bit pin-select input can give the pin to one of three pre-divided clocks, and while it does, alarms cannot start pulses.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset, irq_n_o is 1 with pin_sel_i at 00, and a status read returns 0x00.
- R2: An alm_hit_i strobe sets that alarm's status flag whether its alm_en_i bit is 0 or 1.
- R3: With pin_sel_i at 00, an enabled strobe sampled at a clock edge drives irq_n_o low after that edge, for exactly PULSE_CYC cycles (default 655). irq_n_o then returns to 1.
- R4: A strobe from an alarm whose alm_en_i bit is 0 never drives irq_n_o low.
- R5: A strobe that arrives while a pulse is running sets its flag but neither lengthens nor restarts the pulse.
- R6: With recur_i at 0, an alarm whose flag is set starts no pulse. After a read has cleared the flag, its next strobe starts a pulse again.
- R7: With recur_i at 1, every enabled strobe that finds no pulse running starts a pulse, even when the alarm's flag is already set.
- R8: While rd_sel_i is high, the status byte is captured in the first cycle. It is then presented on rd_bit_o MSB first: bit 7-k before the k-th falling strobe (k counting from 0). Alarm i's flag sits at bit i and the upper bits are 0.
- R9: The flags clear only on the eighth rd_bit_fall_i strobe of a read. A read that stops after seven strobes leaves them set.
- R10: A strobe that lands in the same cycle as the clearing eighth bit leaves its flag set.
- R11: When pin_sel_i is 01, 10 or 11, irq_n_o carries clk_src_i[0], [1] or [2] in that order. Alarm strobes in that state start no pulse, so irq_n_o is 1 once pin_sel_i returns to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alm_hit_i | input | NUM_ALM | One-cycle match strobe for each alarm |
| alm_en_i | input | NUM_ALM | Interrupt enable for each alarm |
| recur_i | input | 1 | 0 selects single-event alarms, 1 selects recurring alarms |
| pin_sel_i | input | 2 | 00 alarm interrupt, 01/10/11 clock source 0/1/2 |
| clk_src_i | input | 3 | Pre-divided clocks that can be routed to the pin |
| rd_sel_i | input | 1 | High for the duration of a status-byte read |
| rd_bit_fall_i | input | 1 | One strobe for each falling bit clock of the read |
| rd_bit_o | output | 1 | Serial status bit for the current bit clock |
| irq_n_o | output | 1 | Active-low interrupt pulse or selected clock |

## Verification
The bench counts the pulse to the cycle, because a counter off by one gives a pulse one cycle too short or too long. It fires a second alarm halfway through a pulse, which catches a design that restarts the counter and gives a pulse of about 1.5 times the nominal width. Reads that stop after seven bits, and a strobe that lands on the clearing eighth bit, catch clear logic that triggers early or loses an event. Single and recurring modes are both run with a flag left set, so a design that ignores the mode either misses a repeat or fires twice.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/1ps
package alarm_irq_pkg;

   // Pin ownership codes; 00 leaves the pin to the alarm pulse.
   typedef enum logic [1:0] {
      PIN_ALARM = 2'b00,
      PIN_SRC0  = 2'b01,
      PIN_SRC1  = 2'b10,
      PIN_SRC2  = 2'b11
   } pin_sel_e;

   localparam int NUM_CLK_SRC = 3;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/alarm_flag_bank.sv
`timescale 1ns/1ps
module alarm_flag_bank #(
   parameter int NUM_ALM = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ALM-1:0] hit_i,
   input  logic               clr_i,
   output logic [NUM_ALM-1:0] flag_o
);

   for (genvar g = 0; g < NUM_ALM; g++) begin : g_flag
      logic flag_q;
      // A set in the clearing cycle wins so that no event is lost.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else if (hit_i[g])
            flag_q <= 1'b1;
         else if (clr_i)
            flag_q <= 1'b0;
      end
      assign flag_o[g] = flag_q;
   end

endmodule

// File: rtl/alarm_read_port.sv
`timescale 1ns/1ps
module alarm_read_port #(
   parameter int NUM_ALM  = 2,
   parameter int STATUS_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_sel_i,
   input  logic               bit_fall_i,
   input  logic [NUM_ALM-1:0] flags_i,
   output logic               clr_o,
   output logic               bit_o
);

   localparam int               CW      = $clog2(STATUS_W);
   localparam logic [CW-1:0]    LAST_IX = CW'(STATUS_W - 1);

   logic [STATUS_W-1:0] status_word;
   logic [STATUS_W-1:0] snap_q;
   logic [CW-1:0]       cnt_q;
   logic                act_q;

   always_comb begin
      status_word              = '0;
      status_word[NUM_ALM-1:0] = flags_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         snap_q <= '0;
      end else if (!rd_sel_i) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (!act_q) begin
         act_q  <= 1'b1;
         cnt_q  <= '0;
         snap_q <= status_word;
      end else if (bit_fall_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign clr_o = act_q && rd_sel_i && bit_fall_i && (cnt_q == LAST_IX);
   assign bit_o = snap_q[LAST_IX - cnt_q];

endmodule

// File: rtl/alarm_pulse_gen.sv
`timescale 1ns/1ps
module alarm_pulse_gen #(
   parameter int NUM_ALM   = 2,
   parameter int PULSE_CYC = 655
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ALM-1:0] hit_i,
   input  logic [NUM_ALM-1:0] en_i,
   input  logic [NUM_ALM-1:0] flag_i,
   input  logic               recur_i,
   input  logic               allow_i,
   output logic               pulse_n_o
);

   localparam int            CW      = $clog2(PULSE_CYC + 1);
   localparam logic [CW-1:0] LOAD_V  = CW'(PULSE_CYC);

   logic [CW-1:0]      cnt_q;
   logic [NUM_ALM-1:0] arm;
   logic               busy;
   logic               trig;

   // Single-event mode masks alarms whose flag is still pending.
   assign arm  = hit_i & en_i & (recur_i ? {NUM_ALM{1'b1}} : ~flag_i);
   assign busy = (cnt_q != '0);
   assign trig = (|arm) && allow_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (trig)
         cnt_q <= LOAD_V;
      else if (busy)
         cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_n_o = !busy;

endmodule

// File: rtl/alarm_pin_mux.sv
`timescale 1ns/1ps
module alarm_pin_mux
   import alarm_irq_pkg::*;
(
   input  logic [1:0]             sel_i,
   input  logic                   pulse_n_i,
   input  logic [NUM_CLK_SRC-1:0] clk_src_i,
   output logic                   pin_o
);

   always_comb begin
      unique case (pin_sel_e'(sel_i))
         PIN_SRC0: pin_o = clk_src_i[0];
         PIN_SRC1: pin_o = clk_src_i[1];
         PIN_SRC2: pin_o = clk_src_i[2];
         default:  pin_o = pulse_n_i;
      endcase
   end

endmodule

// File: rtl/alarm_irq_ctrl.sv
`timescale 1ns/1ps
module alarm_irq_ctrl
   import alarm_irq_pkg::*;
#(
   parameter int NUM_ALM   = 2,
   parameter int PULSE_CYC = 655,
   parameter int STATUS_W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_ALM-1:0]     alm_hit_i,
   input  logic [NUM_ALM-1:0]     alm_en_i,
   input  logic                   recur_i,
   input  logic [1:0]             pin_sel_i,
   input  logic [NUM_CLK_SRC-1:0] clk_src_i,
   input  logic                   rd_sel_i,
   input  logic                   rd_bit_fall_i,
   output logic                   rd_bit_o,
   output logic                   irq_n_o
);

   if (NUM_ALM < 1 || NUM_ALM > STATUS_W) begin : g_bad_alm
      $error("NUM_ALM must be between 1 and STATUS_W");
   end
   if (!is_pow2(STATUS_W) || STATUS_W < 2) begin : g_bad_status
      $error("STATUS_W must be a power of two of at least 2");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("PULSE_CYC must be at least 1");
   end

   logic [NUM_ALM-1:0] flag_q;
   logic               rd_clr;
   logic               pulse_n;
   logic               pin_is_alarm;

   assign pin_is_alarm = (pin_sel_e'(pin_sel_i) == PIN_ALARM);

   alarm_flag_bank #(.NUM_ALM(NUM_ALM)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (alm_hit_i),
      .clr_i  (rd_clr),
      .flag_o (flag_q)
   );

   alarm_read_port #(.NUM_ALM(NUM_ALM), .STATUS_W(STATUS_W)) u_read (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_sel_i   (rd_sel_i),
      .bit_fall_i (rd_bit_fall_i),
      .flags_i    (flag_q),
      .clr_o      (rd_clr),
      .bit_o      (rd_bit_o)
   );

   alarm_pulse_gen #(.NUM_ALM(NUM_ALM), .PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_i     (alm_hit_i),
      .en_i      (alm_en_i),
      .flag_i    (flag_q),
      .recur_i   (recur_i),
      .allow_i   (pin_is_alarm),
      .pulse_n_o (pulse_n)
   );

   alarm_pin_mux u_pin (
      .sel_i     (pin_sel_i),
      .pulse_n_i (pulse_n),
      .clk_src_i (clk_src_i),
      .pin_o     (irq_n_o)
   );

endmodule

// File: rtl/alarm_irq_chk.sv
`timescale 1ns/1ps
module alarm_irq_chk #(
   parameter int NUM_ALM   = 2,
   parameter int PULSE_CYC = 655
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_ALM-1:0] alm_hit_i,
   input logic [NUM_ALM-1:0] alm_en_i,
   input logic [1:0]         pin_sel_i,
   input logic               rd_sel_i,
   input logic               rd_bit_fall_i,
   input logic [NUM_ALM-1:0] flag_q,
   input logic               pulse_n
);

   int low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= 0;
      else if (!pulse_n)
         low_cnt <= (low_cnt > PULSE_CYC) ? low_cnt : low_cnt + 1;
      else
         low_cnt <= 0;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|alm_hit_i) |=> ((flag_q & $past(alm_hit_i)) == $past(alm_hit_i))); // R2

   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_n) |-> ($past(|(alm_hit_i & alm_en_i)) && ($past(pin_sel_i) == 2'b00))); // R4

   AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= PULSE_CYC); // R5

   AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_n) |-> (low_cnt == PULSE_CYC)); // R3

   AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(flag_q) & ~flag_q)) |-> $past(rd_sel_i && rd_bit_fall_i)); // R9

endmodule

bind alarm_irq_ctrl alarm_irq_chk #(.NUM_ALM(NUM_ALM), .PULSE_CYC(PULSE_CYC)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .alm_hit_i     (alm_hit_i),
   .alm_en_i      (alm_en_i),
   .pin_sel_i     (pin_sel_i),
   .rd_sel_i      (rd_sel_i),
   .rd_bit_fall_i (rd_bit_fall_i),
   .flag_q        (flag_q),
   .pulse_n       (pulse_n)
);

// File: tb/alarm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb;

   localparam int NA = 2;
   localparam int PW = 655;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NA-1:0] hit = '0;
   logic [NA-1:0] en = '0;
   logic          recur = 1'b0;
   logic [1:0]    psel = 2'b00;
   logic [2:0]    src = 3'b000;
   logic          rd_sel = 1'b0;
   logic          bfall = 1'b0;
   logic          rd_bit;
   logic          irq_n;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   alarm_irq_ctrl #(.NUM_ALM(NA), .PULSE_CYC(PW), .STATUS_W(8)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .alm_hit_i     (hit),
      .alm_en_i      (en),
      .recur_i       (recur),
      .pin_sel_i     (psel),
      .clk_src_i     (src),
      .rd_sel_i      (rd_sel),
      .rd_bit_fall_i (bfall),
      .rd_bit_o      (rd_bit),
      .irq_n_o       (irq_n)
   );

   // {pin select, clock sources, expected pin}
   localparam logic [5:0] MUX_TAB [8] = '{
      {2'b00, 3'b111, 1'b1}, {2'b00, 3'b000, 1'b1},
      {2'b01, 3'b001, 1'b1}, {2'b01, 3'b110, 1'b0},
      {2'b10, 3'b010, 1'b1}, {2'b10, 3'b101, 1'b0},
      {2'b11, 3'b100, 1'b1}, {2'b11, 3'b011, 1'b0}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reads nbits of the status byte; last_hit is driven with the final strobe.
   task automatic read_bits(input int nbits, input logic [NA-1:0] last_hit,
                            output logic [7:0] b);
      b = '0;
      rd_sel = 1'b1;
      step();
      for (int k = 0; k < nbits; k++) begin
         b[7-k] = rd_bit;
         bfall = 1'b1;
         if (k == nbits - 1) hit = last_hit;
         step();
         bfall = 1'b0;
         hit = '0;
      end
      rd_sel = 1'b0;
      step();
   endtask

   task automatic pulse_alarm(input logic [NA-1:0] h);
      hit = h;
      step();
      hit = '0;
   endtask

   initial begin
      #2_000_000;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] b;
      steps(3);
      chk("R1 pin idle in reset", irq_n, 1);
      rst_n = 1'b1;
      step();
      chk("R1 pin idle after reset", irq_n, 1);
      read_bits(8, '0, b);
      chk("R1 status after reset", b, 8'h00);

      // Table walk over pin ownership (R11)
      for (int i = 0; i < 8; i++) begin
         psel = MUX_TAB[i][5:4];
         src  = MUX_TAB[i][3:1];
         #1;
         chk($sformatf("R11 mux row %0d", i), irq_n, MUX_TAB[i][0]);
      end
      psel = 2'b00; src = 3'b000;
      step();

      // R4 and R2: disabled alarm sets its flag only
      en = 2'b00;
      pulse_alarm(2'b01);
      chk("R4 no pulse when disabled", irq_n, 1);
      steps(5);
      chk("R4 still idle", irq_n, 1);
      read_bits(8, '0, b);
      chk("R2 flag set while disabled", b, 8'h01);

      // R3 pulse width, single mode
      en = 2'b11; recur = 1'b0;
      pulse_alarm(2'b01);
      chk("R3 pulse starts", irq_n, 0);
      steps(PW - 1);
      chk("R3 low at last cycle", irq_n, 0);
      step();
      chk("R3 released after width", irq_n, 1);

      // R6: flag still set, no new pulse
      pulse_alarm(2'b01);
      chk("R6 pending flag blocks pulse", irq_n, 1);
      steps(10);
      chk("R6 still idle", irq_n, 1);
      read_bits(8, '0, b);
      chk("R8 status byte alarm0", b, 8'h01);
      pulse_alarm(2'b01);
      chk("R6 pulse after clear", irq_n, 0);

      // R5: second alarm midway, no extension
      steps(300);
      pulse_alarm(2'b10);
      chk("R5 still low after extra hit", irq_n, 0);
      steps(PW - 302);
      chk("R5 low at original last cycle", irq_n, 0);
      step();
      chk("R5 not extended", irq_n, 1);
      read_bits(8, '0, b);
      chk("R8 status byte both alarms", b, 8'h03);

      // R7: recurring mode, flag left set
      recur = 1'b1;
      pulse_alarm(2'b10);
      chk("R7 first recurring pulse", irq_n, 0);
      steps(PW);
      chk("R7 first pulse ends", irq_n, 1);
      pulse_alarm(2'b10);
      chk("R7 repeat pulse with flag set", irq_n, 0);
      steps(PW);
      chk("R7 repeat pulse ends", irq_n, 1);
      read_bits(8, '0, b);
      chk("R8 status byte alarm1", b, 8'h02);

      // R9: seven bits do not clear
      recur = 1'b0; en = 2'b00;
      pulse_alarm(2'b11);
      read_bits(7, '0, b);
      chk("R9 seven-bit read upper bits", b, 8'h02);
      read_bits(8, '0, b);
      chk("R9 flags kept after seven bits", b, 8'h03);
      read_bits(8, '0, b);
      chk("R9 flags cleared after eighth bit", b, 8'h00);

      // R10: set on the clearing bit wins
      pulse_alarm(2'b11);
      read_bits(8, 2'b01, b);
      chk("R10 read before collision", b, 8'h03);
      read_bits(8, '0, b);
      chk("R10 set beats clear", b, 8'h01);

      // R11: clock on pin blocks alarm pulses
      en = 2'b11;
      read_bits(8, '0, b);
      psel = 2'b10; src = 3'b010;
      #1;
      pulse_alarm(2'b01);
      chk("R11 pin carries clock", irq_n, 1);
      src = 3'b000;
      #1;
      chk("R11 pin follows clock low", irq_n, 0);
      psel = 2'b00;
      #1;
      chk("R11 no pulse started while clock out", irq_n, 1);
      steps(3);
      chk("R11 still idle", irq_n, 1);
      read_bits(8, '0, b);
      chk("R2 flag set while pin was clock", b, 8'h01);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule